// File: doc/BRIEF.md
# Printer Port Host Register Block

This block is the byte-wide register file that a host processor sees for a standard parallel printer port. It exposes three registers on a small synchronous register bus: an outgoing/incoming data byte, a printer status byte and a port control byte. The printer side is not driven through real pins. The block models it internally, so software can run an ordinary print loop against the registers alone.

When software raises the strobe bit through a control write, with the printer initialised and selected, the data byte last written is handed out once on a byte stream output with a single-cycle valid pulse. Each later status read then advances an emulated acknowledge/busy handshake, so a polling driver sees the expected sequence of status values. A control write with the initialise bit low puts the status into a fixed ready pattern. A control write with the strobe bit low can raise a level interrupt when interrupts were enabled. Reading status clears that interrupt. A separate input lets the printer side load the byte that data reads return when the port is turned around for input.

Bus writes and reads are single-cycle strobes. Read data is combinational from the addressed register during the read cycle. The side effects of a read or write land on the next rising clock edge. When a write and a read are asserted together, the write wins and the read causes no side effect.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, the data read returns 0xFF, status reads 0xD9, control reads 0xCC, and both the interrupt output and the byte-valid output are low.
- R2: Only the low three address bits are decoded. Offset 0 is data, 1 is status and 2 is control. Reads of offsets 3 to 7 return 0xFF. Writes to offsets 1 and 3 to 7 change no register.
- R3: Every control write stores the written value with bits 7 and 6 forced to 1.
- R4: A control write with the initialise bit (bit 2) at 0 sets status to 0xD8: bits 7 (busy, inverted), 6 (acknowledge), 4 (online) and 3 (error, inverted) set, and all other bits clear.
- R5: A control write with initialise (bit 2), select (bit 3) and strobe (bit 0) all set clears status bit 7. If the stored strobe bit was 0 before the write, the stored data byte is emitted once, with the valid output high for exactly one cycle. If the stored strobe bit was already 1, nothing is emitted.
- R6: A control write with initialise and select set and strobe clear raises the interrupt only if the stored control had interrupt-enable (bit 4) set before the write. The interrupt output goes high on the clock edge of that write. A control write with select clear changes neither status nor the interrupt.
- R7: A status read returns the status held before the read and drops the interrupt output on that clock edge. A data write leaves the interrupt unchanged.
- R8: When status bit 7 is 0 and the stored control strobe bit is 0, a status read steps the handshake: if acknowledge (bit 6) is set it is cleared, otherwise bits 7 and 6 are both set. In every other case a status read leaves status unchanged.
- R9: A data read returns the byte loaded from the printer side when control direction (bit 5) is 1, and returns the last byte written by the host otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address; only bits 2:0 decoded |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Read data of the addressed register |
| rx_load | input | 1 | Printer side loads the input data byte |
| rx_byte | input | 8 | Input data byte from the printer side |
| tx_valid | output | 1 | One-cycle pulse marking an emitted byte |
| tx_data | output | 8 | Emitted data byte |
| irq | output | 1 | Level interrupt request |

## Verification
Read data is due in the same cycle as the read strobe. The bench therefore samples `rdata` shortly after driving the strobe on the falling edge, before the rising edge that applies the read's side effect. Register updates, the interrupt level and the emitted byte with its valid pulse all appear one cycle after the strobe. Each is checked on the falling edge that follows the clock edge that took the write or read. The valid pulse is checked again one cycle later, to confirm that it has dropped.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;

  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  // register offsets within the decoded low address bits
  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

  // status bit positions
  localparam int ST_NBUSY  = 7;
  localparam int ST_ACK    = 6;
  localparam int ST_PAPER  = 5;
  localparam int ST_ONLINE = 4;
  localparam int ST_NERR   = 3;
  localparam int ST_TMO    = 0;

  // control bit positions
  localparam int CT_DIR    = 5;
  localparam int CT_IRQEN  = 4;
  localparam int CT_SEL    = 3;
  localparam int CT_INIT   = 2;
  localparam int CT_AUTOLF = 1;
  localparam int CT_STB    = 0;

  localparam logic [BYTE_W-1:0] STAT_RST   = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_READY = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hCC;
  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] DATA_RST   = 8'hFF;
  localparam logic [BYTE_W-1:0] UNMAPPED   = 8'hFF;

  // classified control write
  typedef struct packed {
    logic init_low;   // write with initialise clear
    logic fire;       // initialise, select and strobe set
    logic hold;       // initialise and select set, strobe clear
  } ctl_evt_t;

endpackage

// File: rtl/prn_data_path.sv
module prn_data_path
  import prn_port_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic [DW-1:0] wdata,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_byte,
  input  logic          dir_in,
  output logic [DW-1:0] data_rd,
  output logic [DW-1:0] host_byte
);

  logic [DW-1:0] host_q, host_d;
  logic [DW-1:0] peer_q, peer_d;

  always_comb begin
    host_d = host_q;
    peer_d = peer_q;
    if (data_we) host_d = wdata;
    if (rx_load) peer_d = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q <= DW'(DATA_RST);
      peer_q <= DW'(DATA_RST);
    end else begin
      if (data_we) host_q <= host_d;
      if (rx_load) peer_q <= peer_d;
    end
  end

  assign data_rd   = dir_in ? peer_q : host_q;
  assign host_byte = host_q;

endmodule

// File: rtl/prn_ctl_path.sv
module prn_ctl_path
  import prn_port_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] host_byte,
  output logic [DW-1:0] ctrl_q,
  output ctl_evt_t      evt,
  output logic          pend_set,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data
);

  logic [DW-1:0] ctrl_d;
  logic          emit_req;
  logic          tx_valid_q;
  logic [DW-1:0] tx_data_q, tx_data_d;

  always_comb begin
    ctrl_d       = wdata | DW'(CTRL_FORCE);
    evt.init_low = ctrl_we & ~ctrl_d[CT_INIT];
    evt.fire     = ctrl_we & ctrl_d[CT_INIT] & ctrl_d[CT_SEL] & ctrl_d[CT_STB];
    evt.hold     = ctrl_we & ctrl_d[CT_INIT] & ctrl_d[CT_SEL] & ~ctrl_d[CT_STB];
    // strobe edge judged against the value stored before this write
    emit_req     = evt.fire & ~ctrl_q[CT_STB];
    pend_set     = evt.hold & ctrl_q[CT_IRQEN];
    tx_data_d    = emit_req ? host_byte : tx_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= DW'(CTRL_RST);
      tx_valid_q <= 1'b0;
      tx_data_q  <= DW'(DATA_RST);
    end else begin
      if (ctrl_we)  ctrl_q    <= ctrl_d;
      if (emit_req) tx_data_q <= tx_data_d;
      tx_valid_q <= emit_req;
    end
  end

  assign tx_valid = tx_valid_q;
  assign tx_data  = tx_data_q;

endmodule

// File: rtl/prn_stat_path.sv
module prn_stat_path
  import prn_port_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_evt_t      evt,
  input  logic          pend_set,
  input  logic          stat_rd,
  input  logic          ctrl_stb,
  input  logic          irq_upd,
  output logic [DW-1:0] stat_q,
  output logic          irq
);

  logic [DW-1:0] stat_d;
  logic          pend_q, pend_d;
  logic          irq_q;
  logic          step;

  always_comb begin
    stat_d = stat_q;
    step   = stat_rd & ~stat_q[ST_NBUSY] & ~ctrl_stb;
    if (evt.init_low) begin
      stat_d = DW'(STAT_READY);
    end else if (evt.fire) begin
      stat_d[ST_NBUSY] = 1'b0;
    end else if (step) begin
      if (stat_q[ST_ACK]) begin
        stat_d[ST_ACK] = 1'b0;
      end else begin
        stat_d[ST_ACK]   = 1'b1;
        stat_d[ST_NBUSY] = 1'b1;
      end
    end

    pend_d = pend_q;
    if (stat_rd)       pend_d = 1'b0;
    else if (pend_set) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= DW'(STAT_RST);
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (evt.init_low | evt.fire | step) stat_q <= stat_d;
      if (stat_rd | pend_set)             pend_q <= pend_d;
      if (irq_upd)                        irq_q  <= pend_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_port_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  input  logic              rx_load,
  input  logic [7:0]        rx_byte,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);

  localparam int DW = BYTE_W;

  logic [OFS_W-1:0] ofs;
  logic             data_we, ctrl_we, stat_rd, irq_upd;
  logic [DW-1:0]    data_rd, host_byte, ctrl_q, stat_q;
  ctl_evt_t         evt;
  logic             pend_set;

  assign ofs     = addr[OFS_W-1:0];
  assign data_we = wr_en & (ofs == OFS_DATA);
  assign ctrl_we = wr_en & (ofs == OFS_CTRL);
  assign stat_rd = rd_en & ~wr_en & (ofs == OFS_STAT);
  assign irq_upd = data_we | ctrl_we | stat_rd;

  prn_data_path #(.DW(DW)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_we   (data_we),
    .wdata     (wdata),
    .rx_load   (rx_load),
    .rx_byte   (rx_byte),
    .dir_in    (ctrl_q[CT_DIR]),
    .data_rd   (data_rd),
    .host_byte (host_byte)
  );

  prn_ctl_path #(.DW(DW)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .wdata     (wdata),
    .host_byte (host_byte),
    .ctrl_q    (ctrl_q),
    .evt       (evt),
    .pend_set  (pend_set),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data)
  );

  prn_stat_path #(.DW(DW)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .pend_set (pend_set),
    .stat_rd  (stat_rd),
    .ctrl_stb (ctrl_q[CT_STB]),
    .irq_upd  (irq_upd),
    .stat_q   (stat_q),
    .irq      (irq)
  );

  always_comb begin
    case (ofs)
      OFS_DATA: rdata = data_rd;
      OFS_STAT: rdata = stat_q;
      OFS_CTRL: rdata = ctrl_q;
      default:  rdata = UNMAPPED;
    endcase
  end

endmodule

// File: rtl/prn_port_regs_chk.sv
module prn_port_regs_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              tx_valid,
  input logic              irq,
  input logic [7:0]        stat_q
);

  // R3: control readback always has its top two bits set
  a_r3_ctrl_top_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[2:0] == 3'd2) |-> (rdata[7:6] == 2'b11));

  // R2: unmapped offsets read as all ones
  a_r2_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[2:0] > 3'd2) |-> (rdata == 8'hFF));

  // R4: initialise-low control write lands the ready pattern
  a_r4_init_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[2:0] == 3'd2 && !wdata[2]) |=> (stat_q == 8'hD8));

  // R5: an emitted byte is marked for a single cycle only
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);

  // R6: the interrupt only rises after a control write
  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_en && addr[2:0] == 3'd2));

  // R7: a status read drops the interrupt
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr[2:0] == 3'd1) |=> !irq);

endmodule

bind prn_port_regs prn_port_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .wdata    (wdata),
  .rdata    (rdata),
  .tx_valid (tx_valid),
  .irq      (irq),
  .stat_q   (stat_q)
);

// File: tb/prn_port_regs_test.sv
`timescale 1ns/1ps
module prn_port_regs_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic       wr_en, rd_en, rx_load;
  logic [7:0] wdata, rx_byte, rdata, tx_data;
  logic       tx_valid, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  prn_port_regs #(.ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .rx_load(rx_load), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic load_rx(input logic [7:0] d);
    @(negedge clk);
    rx_byte = d; rx_load = 1'b1;
    @(negedge clk);
    rx_load = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(4'd0, v); check("R1 data", v, 8'hFF);
    rd(4'd1, v); check("R1 status", v, 8'hD9);
    rd(4'd2, v); check("R1 control", v, 8'hCC);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
    for (int o = 3; o < 8; o++) begin
      rd(4'(o), v); check("R2 unmapped read", v, 8'hFF);
    end
  endtask

  task automatic t_ctrl_init();
    logic [7:0] v;
    wr(4'd2, 8'h0C); rd(4'd2, v); check("R3 forced bits", v, 8'hCC);
    wr(4'd2, 8'h00); rd(4'd2, v); check("R3 forced bits zero", v, 8'hC0);
    rd(4'd1, v); check("R4 ready status", v, 8'hD8);
  endtask

  task automatic t_strobe();
    logic [7:0] v;
    wr(4'd0, 8'h5A);
    wr(4'd2, 8'h0C);
    check("R5 no emit on low strobe", {7'd0, tx_valid}, 8'h00);
    wr(4'd2, 8'h0D);
    check("R5 emit valid", {7'd0, tx_valid}, 8'h01);
    check("R5 emit data", tx_data, 8'h5A);
    @(negedge clk);
    check("R5 valid one cycle", {7'd0, tx_valid}, 8'h00);
    wr(4'd2, 8'h0D);
    check("R5 no re-emit", {7'd0, tx_valid}, 8'h00);
    rd(4'd1, v); check("R5 busy cleared", v, 8'h58);
  endtask

  task automatic t_handshake();
    logic [7:0] v;
    rd(4'd1, v); check("R8 no step while strobe high", v, 8'h58);
    wr(4'd2, 8'h0C);
    rd(4'd1, v); check("R8 step 1 read", v, 8'h58);
    rd(4'd1, v); check("R8 ack cleared", v, 8'h18);
    rd(4'd1, v); check("R8 ack and busy set", v, 8'hD8);
    rd(4'd1, v); check("R8 hold when busy set", v, 8'hD8);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(4'd2, 8'h1C);
    check("R6 enable not yet stored", {7'd0, irq}, 8'h00);
    wr(4'd2, 8'h1C);
    check("R6 irq raised", {7'd0, irq}, 8'h01);
    wr(4'd0, 8'h33);
    check("R7 data write keeps irq", {7'd0, irq}, 8'h01);
    rd(4'd1, v); check("R7 status value", v, 8'hD8);
    check("R7 irq cleared", {7'd0, irq}, 8'h00);
    wr(4'd2, 8'h15);
    check("R6 select clear no emit", {7'd0, tx_valid}, 8'h00);
    wr(4'd2, 8'h14);
    check("R6 select clear no irq", {7'd0, irq}, 8'h00);
    rd(4'd1, v); check("R6 select clear status kept", v, 8'hD8);
  endtask

  task automatic t_dir_decode();
    logic [7:0] v;
    load_rx(8'hA5);
    wr(4'd2, 8'h2C);
    rd(4'd0, v); check("R9 input byte", v, 8'hA5);
    wr(4'd2, 8'h0C);
    rd(4'd0, v); check("R9 host byte", v, 8'h33);
    rd(4'd8, v); check("R2 upper bits ignored", v, 8'h33);
    wr(4'd3, 8'h00);
    wr(4'd1, 8'h00);
    wr(4'd9, 8'h77);
    rd(4'd0, v); check("R2 stray write data", v, 8'h33);
    rd(4'd1, v); check("R2 status not writable", v, 8'hD8);
    rd(4'd2, v); check("R2 upper-bit alias control", v, 8'hCC);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0;
    wdata = '0; rx_load = 1'b0; rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_init();
    t_strobe();
    t_handshake();
    t_irq();
    t_dir_decode();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule